// File: doc/BRIEF.md
# Embedded-Sync Video Frame Capture

This block sits on the 27 MHz sampling clock of a video decoder that delivers an 8-bit 4:2:2 stream with its timing embedded in the data: each line carries a start-of-active-video code and an end-of-active-video code, and no separate horizontal or vertical sync wires exist. The block finds those codes, follows field and line framing from them, and on a push-button request captures exactly one frame. A frame is one field with F=0 followed by one field with F=1.

Every active-video byte of the captured frame goes to the write port of an external FIFO as one 11-bit word. Three framing bits travel with the byte: the field it belongs to, whether it opens a line, and whether it opens the frame. Timing-reference codes, horizontal blanking and vertical-blanking lines never reach the FIFO. The controller runs as four states:

- `ST_IDLE`: waiting for a request. A synchronised button edge moves it to `ST_ARMED`.
- `ST_ARMED`: waiting for a timing code whose F bit has changed from 1 to 0. That change moves it to `ST_FIELD_A`.
- `ST_FIELD_A`: capturing the F=0 field. A change of F from 0 to 1 moves it to `ST_FIELD_B`.
- `ST_FIELD_B`: capturing the F=1 field. The next change of F from 1 to 0 returns it to `ST_IDLE`.

Top module: `vcap_frame_grab`

## Requirements
- R1: A timing-reference code is the byte run 0xFF, 0x00, 0x00, XY. In XY, bit 6 is the field flag F, bit 5 is the vertical-blanking flag V, and bit 4 is H. H=0 marks start of active video (SAV) and H=1 marks end of active video (EAV). No byte of a code is ever written to the FIFO.
- R2: `btn_raw` passes through two flip-flops and is edge-detected. Only a rising edge seen in `ST_IDLE` starts a capture. Presses seen while `busy` is high are ignored. `busy` is high from the accepted press until the capture ends.
- R3: The capture starts at the first timing code after the request whose F changes from 1 to 0. It covers that F=0 field and the F=1 field that follows, and it ends at the next change of F from 1 to 0. Lines outside this window are not written.
- R4: Only bytes that lie between an SAV with V=0 and the next EAV are written. Blanking bytes, SAV codes with V=1, and the 0xFF/0x00/0x00 prefix of the closing EAV are not written. Written bytes keep their arrival order.
- R5: The FIFO word layout is: bits [7:0] the video byte, bit 8 start-of-frame, bit 9 start-of-line, bit 10 the F value from the SAV of that line.
- R6: Start-of-line is 1 only on the first byte after each captured SAV. Start-of-frame is 1 only on the first word of a capture, and that word also has start-of-line set.
- R7: When `fifo_full` is high, a word that would be written is dropped and `fifo_wr` stays low. `overflow` is then set, and it stays set until reset.
- R8: Without an accepted request, no word is written, however many frames pass.
- R9: While `rst_n` is low, `fifo_wr`, `busy` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_byte | input | 8 | Video byte stream with embedded timing codes |
| btn_raw | input | 1 | Unsynchronised capture button, active high |
| fifo_full | input | 1 | FIFO cannot take a word this cycle |
| fifo_wr | output | 1 | FIFO write strobe, one cycle per word |
| fifo_data | output | 11 | {field, start-of-line, start-of-frame, byte} |
| overflow | output | 1 | Sticky: a word was dropped because the FIFO was full |
| busy | output | 1 | A request has been accepted and the capture has not finished |

## Verification
The bench drives a frame table whose first field has F=1 and whose final line reopens an F=0 field. This checks that the capture window is bounded by the F changes. A design that armed on F level instead of on its change, or that missed the closing change, would write an extra field or a wrong number of words.

The word-by-word comparison targets the three prefix bytes of each EAV. A design without a pipeline long enough to retract them would append 0xFF, 0x00, 0x00 to every captured line. The same comparison also catches start-of-line and start-of-frame bits that are placed wrongly.

Three further runs cover the remaining corners:
- A second press during a capture must change neither the output nor the end of the capture, so a design that re-armed would write a second frame.
- A stream with no request must produce no words.
- A capture made while the FIFO is full must produce no strobes and must leave `overflow` set after the FIFO has space again.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FIELD_A,
        ST_FIELD_B
    } cap_state_t;

    // Framing tag carried beside each byte through the look-back pipeline
    typedef struct packed {
        logic fld;
        logic sol;
        logic sof;
        logic mark;
    } px_tag_t;

    localparam int TRS_PREFIX_LEN = 3;

endpackage

// File: rtl/vcap_btn_sync.sv
module vcap_btn_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= btn_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[SYNC_STAGES-1];
    end

    assign press = chain[SYNC_STAGES-1] & ~prev;

endmodule

// File: rtl/vcap_trs_detect.sv
module vcap_trs_detect
    import vcap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_in,
    output logic              trs_hit,
    output logic              trs_f,
    output logic              trs_v,
    output logic              trs_h,
    output logic [DATA_W-1:0] lag_byte
);
    localparam int F_POS = DATA_W - 2;
    localparam int V_POS = DATA_W - 3;
    localparam int H_POS = DATA_W - 4;

    // hist[0] is the byte of the previous cycle, hist[2] the oldest
    logic [DATA_W-1:0] hist [TRS_PREFIX_LEN];

    generate
        for (genvar i = 0; i < TRS_PREFIX_LEN; i++) begin : g_hist
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) hist[i] <= '0;
                    else        hist[i] <= byte_in;
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) hist[i] <= '0;
                    else        hist[i] <= hist[i-1];
                end
            end
        end
    endgenerate

    assign trs_hit  = (hist[2] == {DATA_W{1'b1}}) && (hist[1] == '0) && (hist[0] == '0);
    assign trs_f    = byte_in[F_POS];
    assign trs_v    = byte_in[V_POS];
    assign trs_h    = byte_in[H_POS];
    assign lag_byte = hist[TRS_PREFIX_LEN-1];

endmodule

// File: rtl/vcap_capture_ctrl.sv
module vcap_capture_ctrl
    import vcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press,
    input  logic trs_hit,
    input  logic trs_f,
    output logic busy,
    output logic capturing,
    output logic frame_start
);
    cap_state_t state, state_nx;
    logic       last_f;
    logic       f_fall;
    logic       f_rise;

    assign f_fall = trs_hit && !trs_f &&  last_f;
    assign f_rise = trs_hit &&  trs_f && !last_f;

    // State register and field history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            last_f <= 1'b0;
        end else begin
            state <= state_nx;
            if (trs_hit) last_f <= trs_f;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_nx    = state;
        busy        = 1'b1;
        capturing   = 1'b0;
        frame_start = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (press) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (f_fall) begin
                    state_nx    = ST_FIELD_A;
                    frame_start = 1'b1;
                end
            end
            ST_FIELD_A: begin
                capturing = 1'b1;
                if (f_rise) state_nx = ST_FIELD_B;
            end
            ST_FIELD_B: begin
                capturing = 1'b1;
                if (f_fall) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/vcap_pixel_writer.sv
module vcap_pixel_writer
    import vcap_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trs_hit,
    input  logic              trs_f,
    input  logic              trs_v,
    input  logic              trs_h,
    input  logic [DATA_W-1:0] lag_byte,
    input  logic              capturing,
    input  logic              frame_start,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              overflow
);
    logic    in_line;
    logic    sol_pend;
    logic    sof_pend;
    logic    cur_f;
    px_tag_t tag_in;
    px_tag_t tag [TRS_PREFIX_LEN];
    logic    leave;

    // Tag for the byte entering the look-back pipeline this cycle
    always_comb begin
        tag_in.mark = in_line && capturing && !trs_hit;
        tag_in.sol  = tag_in.mark && sol_pend;
        tag_in.sof  = tag_in.mark && sof_pend;
        tag_in.fld  = cur_f;
    end

    // Line tracking from timing codes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_line  <= 1'b0;
            sol_pend <= 1'b0;
            sof_pend <= 1'b0;
            cur_f    <= 1'b0;
        end else begin
            if (trs_hit) begin
                if (trs_h) begin
                    in_line <= 1'b0;
                end else begin
                    in_line  <= !trs_v;
                    sol_pend <= !trs_v;
                    cur_f    <= trs_f;
                end
            end else if (tag_in.mark) begin
                sol_pend <= 1'b0;
            end
            if (frame_start)      sof_pend <= 1'b1;
            else if (tag_in.mark) sof_pend <= 1'b0;
        end
    end

    // Tags move with the bytes; a timing code retracts the prefix bytes
    generate
        for (genvar i = 0; i < TRS_PREFIX_LEN; i++) begin : g_tag
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) tag[i] <= '0;
                    else        tag[i] <= tag_in;
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        tag[i] <= '0;
                    end else begin
                        tag[i]      <= tag[i-1];
                        tag[i].mark <= tag[i-1].mark && !trs_hit;
                    end
                end
            end
        end
    endgenerate

    assign leave = tag[TRS_PREFIX_LEN-1].mark && !trs_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
            overflow  <= 1'b0;
        end else begin
            fifo_wr   <= leave && !fifo_full;
            fifo_data <= {tag[TRS_PREFIX_LEN-1].fld,
                          tag[TRS_PREFIX_LEN-1].sol,
                          tag[TRS_PREFIX_LEN-1].sof,
                          lag_byte};
            if (leave && fifo_full) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/vcap_frame_grab.sv
module vcap_frame_grab
    import vcap_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = DATA_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] vid_byte,
    input  logic              btn_raw,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              overflow,
    output logic              busy
);
    logic              press;
    logic              trs_hit;
    logic              trs_f;
    logic              trs_v;
    logic              trs_h;
    logic [DATA_W-1:0] lag_byte;
    logic              capturing;
    logic              frame_start;

    vcap_btn_sync #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_raw (btn_raw),
        .press   (press)
    );

    vcap_trs_detect #(.DATA_W(DATA_W)) u_trs (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (vid_byte),
        .trs_hit  (trs_hit),
        .trs_f    (trs_f),
        .trs_v    (trs_v),
        .trs_h    (trs_h),
        .lag_byte (lag_byte)
    );

    vcap_capture_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .press       (press),
        .trs_hit     (trs_hit),
        .trs_f       (trs_f),
        .busy        (busy),
        .capturing   (capturing),
        .frame_start (frame_start)
    );

    vcap_pixel_writer #(.DATA_W(DATA_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .trs_hit     (trs_hit),
        .trs_f       (trs_f),
        .trs_v       (trs_v),
        .trs_h       (trs_h),
        .lag_byte    (lag_byte),
        .capturing   (capturing),
        .frame_start (frame_start),
        .fifo_full   (fifo_full),
        .fifo_wr     (fifo_wr),
        .fifo_data   (fifo_data),
        .overflow    (overflow)
    );

endmodule

// File: rtl/vcap_frame_grab_chk.sv
module vcap_frame_grab_chk #(
    parameter int WORD_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic [WORD_W-1:0] fifo_data,
    input logic              overflow,
    input logic              busy
);
    p_no_wr_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !$past(fifo_full));

    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_overflow_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(fifo_full));

    p_wr_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(busy));

    p_sof_is_sol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_data[WORD_W-3]) |-> fifo_data[WORD_W-2]);

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r9: assert (!fifo_wr || $isunknown(fifo_wr));
        end
    end

endmodule

bind vcap_frame_grab vcap_frame_grab_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_full (fifo_full),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .overflow  (overflow),
    .busy      (busy)
);

// File: tb/vcap_frame_grab_test.sv
module vcap_frame_grab_test;
    localparam int CLK_PERIOD = 37;
    localparam int NLINES     = 10;
    localparam int MAXW       = 128;

    // Line entry: [7] F, [6] V, [5] expected captured, [4:0] byte count
    localparam logic [7:0] LINES [NLINES] = '{
        {1'b1, 1'b1, 1'b0, 5'd4},
        {1'b1, 1'b0, 1'b0, 5'd6},
        {1'b0, 1'b1, 1'b0, 5'd4},
        {1'b0, 1'b0, 1'b1, 5'd8},
        {1'b0, 1'b0, 1'b1, 5'd8},
        {1'b1, 1'b1, 1'b0, 5'd4},
        {1'b1, 1'b0, 1'b1, 5'd8},
        {1'b1, 1'b0, 1'b1, 5'd6},
        {1'b0, 1'b1, 1'b0, 5'd4},
        {1'b0, 1'b0, 1'b0, 5'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  vid_byte = 8'h80;
    logic        btn_raw = 1'b0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr;
    logic [10:0] fifo_data;
    logic        overflow;
    logic        busy;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          dcnt  = 0;
    int          exp_n = 0;
    int          got_n = 0;
    logic [10:0] exp_mem [MAXW];
    logic [10:0] got_mem [MAXW];

    vcap_frame_grab uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vid_byte  (vid_byte),
        .btn_raw   (btn_raw),
        .fifo_full (fifo_full),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .overflow  (overflow),
        .busy      (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            if (got_n < MAXW) got_mem[got_n] = fifo_data;
            got_n = got_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic send(input logic [7:0] b);
        vid_byte = b;
        @(negedge clk);
    endtask

    task automatic send_trs(input logic f, input logic v, input logic h);
        send(8'hFF); send(8'h00); send(8'h00);
        send({1'b1, f, v, h, 4'b0000});
    endtask

    // Walks the line table; expect_cap builds the expected FIFO words (R3 R5 R6)
    task automatic walk(input bit expect_cap, input bit mid_press);
        bit first = 1'b1;
        for (int e = 0; e < NLINES; e++) begin
            logic f, v, cap;
            int   n;
            f = LINES[e][7]; v = LINES[e][6]; cap = LINES[e][5]; n = int'(LINES[e][4:0]);
            if (mid_press) btn_raw = (e == 4);
            send_trs(f, v, 1'b1);
            for (int k = 0; k < 4; k++) send(8'h80);
            send_trs(f, v, 1'b0);
            for (int i = 0; i < n; i++) begin
                logic [7:0] d;
                if (v) begin
                    d = 8'h10;
                end else begin
                    d = 8'h10 + 8'(dcnt % 200);
                    dcnt++;
                    if (expect_cap && cap) begin
                        if (exp_n < MAXW) exp_mem[exp_n] = {f, (i == 0), first, d};
                        exp_n++;
                        first = 1'b0;
                    end
                end
                send(d);
            end
        end
        btn_raw = 1'b0;
        for (int k = 0; k < 8; k++) send(8'h80);
    endtask

    task automatic press();
        btn_raw = 1'b1;
        for (int k = 0; k < 6; k++) send(8'h80);
        btn_raw = 1'b0;
        for (int k = 0; k < 6; k++) send(8'h80);
    endtask

    task automatic compare(input string req);
        check(got_n == exp_n, req, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < MAXW; i++)
            check(got_mem[i] == exp_mem[i], req, got_mem[i], exp_mem[i]);
        got_n = 0;
        exp_n = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        check(fifo_wr == 1'b0, "R9", fifo_wr, 0);
        check(busy == 1'b0, "R9", busy, 0);
        check(overflow == 1'b0, "R9", overflow, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) send(8'h80);

        // R8: no request, no writes
        walk(1'b0, 1'b0);
        compare("R8");
        check(busy == 1'b0, "R8", busy, 0);

        // R2 then R1 R3 R4 R5 R6: one full capture
        press();
        check(busy == 1'b1, "R2", busy, 1);
        walk(1'b1, 1'b0);
        compare("R1 R3 R4 R5 R6");
        check(busy == 1'b0, "R3", busy, 0);

        // R2: press during capture is ignored, no second frame follows
        press();
        walk(1'b1, 1'b1);
        compare("R2");
        check(busy == 1'b0, "R2", busy, 0);
        walk(1'b0, 1'b0);
        compare("R2");

        // R7: full FIFO drops words and raises sticky overflow
        check(overflow == 1'b0, "R7", overflow, 0);
        press();
        fifo_full = 1'b1;
        walk(1'b0, 1'b0);
        fifo_full = 1'b0;
        compare("R7");
        check(overflow == 1'b1, "R7", overflow, 1);
        walk(1'b0, 1'b0);
        check(overflow == 1'b1, "R7", overflow, 1);
        compare("R7");

        summary();
    end

endmodule